// File: doc/BRIEF.md
# Dual-Partition Device Address Router

This block sits between a memory request source and two backing stores of a memory device. One store holds volatile capacity and the other holds persistent capacity. The device exposes a single flat device address space. The volatile capacity always begins at address 0. The persistent capacity follows directly after the volatile capacity. When no volatile capacity is configured, the persistent capacity begins at address 0. Each accepted read or write is steered to the matching store with an address relative to that store. An address beyond both partitions is answered with an error, and neither store is accessed.

The two partition sizes are byte counts on configuration inputs, and either size may be zero. The sizes must be held stable while a request is in flight. From the same inputs the block derives the capacity fields that an identify command reports: total, volatile and persistent, each in 256 MiB units. When the total is not a whole number of units, an alignment error replaces these fields.

The request, response and both store channels use valid/ready handshakes. A request is accepted only while the block is idle, and only one request is in flight at a time. After it is raised, a response stays valid with stable contents until the consumer accepts it. A store request holds its valid, offset, direction and data until the store raises ready. A store answers with a single-cycle response pulse, no earlier than the cycle after it accepted the request. The response consumer may hold rsp_ready low for any number of cycles.

Top module: `dpa_router`

## Requirements
- R1: A device address below the volatile size is sent to the volatile store, with an offset equal to the device address.
- R2: When the volatile size is non-zero, a device address in [vol, vol+pers) is sent to the persistent store, with an offset equal to the device address minus the volatile size.
- R3: When the volatile size is zero, the persistent store serves device addresses from 0, with an offset equal to the device address.
- R4: A device address at or beyond vol+pers gets a response with rsp_err=1 and rsp_rdata=0. No store request is raised for it.
- R5: When vol+pers is a multiple of 2^28 bytes, id_total_units equals (vol+pers)/2^28 and id_align_err is 0.
- R6: When the total is aligned, id_vol_units is floor(vol/2^28) and id_pers_units is floor(pers/2^28). Each is reported in its own field.
- R7: When vol+pers is not a multiple of 2^28, id_align_err is 1 and all three unit fields are 0.
- R8: req_ready is high only when the block is idle. It falls in the cycle after a request is accepted and stays low until the response handshake completes.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_rdata and rsp_err hold their values.
- R10: A store request holds its valid, offset and direction until that store's ready is seen high.
- R11: Write data reaches the selected store unchanged. rsp_rdata carries the data of the selected store's response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_vol_bytes | input | ADDR_W | Volatile partition size in bytes |
| cfg_pers_bytes | input | ADDR_W | Persistent partition size in bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Device address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | DATA_W | Response data (0 on error) |
| rsp_err | output | 1 | Out-of-range error |
| vm_req_valid | output | 1 | Volatile store request valid |
| vm_req_ready | input | 1 | Volatile store ready |
| vm_req_write | output | 1 | Volatile store direction |
| vm_req_offs | output | ADDR_W | Volatile store offset |
| vm_req_wdata | output | DATA_W | Volatile store write data |
| vm_rsp_valid | input | 1 | Volatile store response pulse |
| vm_rsp_rdata | input | DATA_W | Volatile store response data |
| pm_req_valid | output | 1 | Persistent store request valid |
| pm_req_ready | input | 1 | Persistent store ready |
| pm_req_write | output | 1 | Persistent store direction |
| pm_req_offs | output | ADDR_W | Persistent store offset |
| pm_req_wdata | output | DATA_W | Persistent store write data |
| pm_rsp_valid | input | 1 | Persistent store response pulse |
| pm_rsp_rdata | input | DATA_W | Persistent store response data |
| id_total_units | output | ADDR_W-UNIT_SHIFT+1 | Total capacity in 256 MiB units |
| id_vol_units | output | ADDR_W-UNIT_SHIFT+1 | Volatile capacity in 256 MiB units |
| id_pers_units | output | ADDR_W-UNIT_SHIFT+1 | Persistent capacity in 256 MiB units |
| id_align_err | output | 1 | Total capacity not a multiple of 256 MiB |

## Verification
On every cycle, the assertions check the following:
- A request stalled against a store holds its contents.
- A stalled response holds its contents.
- The two stores are never requested together.
- Each store offset lies inside its own partition.
- req_ready is low in the cycle after an accept.
- The alignment error zeroes the unit fields.

The remaining behaviour only shows up in the bench's scenarios. This covers the exact offset chosen at each partition edge, and the shift of the persistent partition to address 0 when the volatile size is zero. It also covers the error path that leaves both stores untouched, write-then-read data integrity, and the floor rounding of the separate unit fields when only the total is aligned.

// File: rtl/dpa_router_pkg.sv
package dpa_router_pkg;

  typedef enum logic [1:0] {
    TGT_VOL  = 2'd0,
    TGT_PERS = 2'd1,
    TGT_NONE = 2'd2
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } st_e;

endpackage

// File: rtl/dpa_map.sv
module dpa_map
  import dpa_router_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] vol_bytes,
  input  logic [ADDR_W-1:0] pers_bytes,
  output tgt_e              tgt,
  output logic [ADDR_W-1:0] offs
);

  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] addr_x;
  logic [EXT_W-1:0] vol_end_x;
  logic [EXT_W-1:0] all_end_x;

  assign addr_x    = {1'b0, addr};
  assign vol_end_x = {1'b0, vol_bytes};
  assign all_end_x = vol_end_x + {1'b0, pers_bytes};

  // Volatile is checked first so it wins at address 0.
  // A zero volatile size makes that test always false.
  always_comb begin
    if (addr_x < vol_end_x) begin
      tgt  = TGT_VOL;
      offs = addr;
    end else if (addr_x < all_end_x) begin
      tgt  = TGT_PERS;
      offs = addr - vol_bytes;
    end else begin
      tgt  = TGT_NONE;
      offs = '0;
    end
  end

endmodule

// File: rtl/dpa_capacity.sv
module dpa_capacity #(
  parameter int ADDR_W     = 36,
  parameter int UNIT_SHIFT = 28
) (
  input  logic [ADDR_W-1:0]          vol_bytes,
  input  logic [ADDR_W-1:0]          pers_bytes,
  output logic [ADDR_W-UNIT_SHIFT:0] total_units,
  output logic [ADDR_W-UNIT_SHIFT:0] vol_units,
  output logic [ADDR_W-UNIT_SHIFT:0] pers_units,
  output logic                       align_err
);

  localparam int EXT_W  = ADDR_W + 1;
  localparam int UNIT_W = ADDR_W - UNIT_SHIFT + 1;

  logic [EXT_W-1:0] sum_x;
  logic [EXT_W-1:0] vol_x;
  logic [EXT_W-1:0] pers_x;

  assign vol_x     = {1'b0, vol_bytes};
  assign pers_x    = {1'b0, pers_bytes};
  assign sum_x     = vol_x + pers_x;
  assign align_err = |sum_x[UNIT_SHIFT-1:0];

  // Unit fields are withheld when the total fails the alignment check.
  assign total_units = align_err ? '0 : sum_x[EXT_W-1:UNIT_SHIFT];
  assign vol_units   = align_err ? '0 : UNIT_W'(vol_x[EXT_W-1:UNIT_SHIFT]);
  assign pers_units  = align_err ? '0 : UNIT_W'(pers_x[EXT_W-1:UNIT_SHIFT]);

endmodule

// File: rtl/dpa_rsp_sel.sv
module dpa_rsp_sel
  import dpa_router_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  tgt_e              tgt,
  input  logic              vol_valid,
  input  logic [DATA_W-1:0] vol_data,
  input  logic              pers_valid,
  input  logic [DATA_W-1:0] pers_data,
  output logic              hit,
  output logic [DATA_W-1:0] data
);

  always_comb begin
    unique case (tgt)
      TGT_VOL:  begin hit = vol_valid;  data = vol_data;  end
      TGT_PERS: begin hit = pers_valid; data = pers_data; end
      default:  begin hit = 1'b0;       data = '0;        end
    endcase
  end

endmodule

// File: rtl/dpa_router.sv
module dpa_router
  import dpa_router_pkg::*;
#(
  parameter int ADDR_W     = 36,
  parameter int DATA_W     = 64,
  parameter int UNIT_SHIFT = 28
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          cfg_vol_bytes,
  input  logic [ADDR_W-1:0]          cfg_pers_bytes,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       rsp_err,
  output logic                       vm_req_valid,
  input  logic                       vm_req_ready,
  output logic                       vm_req_write,
  output logic [ADDR_W-1:0]          vm_req_offs,
  output logic [DATA_W-1:0]          vm_req_wdata,
  input  logic                       vm_rsp_valid,
  input  logic [DATA_W-1:0]          vm_rsp_rdata,
  output logic                       pm_req_valid,
  input  logic                       pm_req_ready,
  output logic                       pm_req_write,
  output logic [ADDR_W-1:0]          pm_req_offs,
  output logic [DATA_W-1:0]          pm_req_wdata,
  input  logic                       pm_rsp_valid,
  input  logic [DATA_W-1:0]          pm_rsp_rdata,
  output logic [ADDR_W-UNIT_SHIFT:0] id_total_units,
  output logic [ADDR_W-UNIT_SHIFT:0] id_vol_units,
  output logic [ADDR_W-UNIT_SHIFT:0] id_pers_units,
  output logic                       id_align_err
);

  localparam int NUM_BE = 2;

  st_e               st;
  tgt_e              cur_tgt;
  logic              cur_write;
  logic [ADDR_W-1:0] cur_offs;
  logic [DATA_W-1:0] cur_wdata;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_err_q;

  tgt_e              map_tgt;
  logic [ADDR_W-1:0] map_offs;
  logic              sel_hit;
  logic [DATA_W-1:0] sel_data;
  logic              sel_ready;
  logic              be_valid [NUM_BE];

  dpa_map #(.ADDR_W(ADDR_W)) u_map (
    .addr       (req_addr),
    .vol_bytes  (cfg_vol_bytes),
    .pers_bytes (cfg_pers_bytes),
    .tgt        (map_tgt),
    .offs       (map_offs)
  );

  dpa_capacity #(.ADDR_W(ADDR_W), .UNIT_SHIFT(UNIT_SHIFT)) u_cap (
    .vol_bytes   (cfg_vol_bytes),
    .pers_bytes  (cfg_pers_bytes),
    .total_units (id_total_units),
    .vol_units   (id_vol_units),
    .pers_units  (id_pers_units),
    .align_err   (id_align_err)
  );

  dpa_rsp_sel #(.DATA_W(DATA_W)) u_sel (
    .tgt        (cur_tgt),
    .vol_valid  (vm_rsp_valid),
    .vol_data   (vm_rsp_rdata),
    .pers_valid (pm_rsp_valid),
    .pers_data  (pm_rsp_rdata),
    .hit        (sel_hit),
    .data       (sel_data)
  );

  // One request lane per store: valid only while issuing to that target.
  for (genvar g = 0; g < NUM_BE; g++) begin : g_lane
    localparam tgt_e LANE_TGT = (g == 0) ? TGT_VOL : TGT_PERS;
    assign be_valid[g] = (st == ST_ISSUE) && (cur_tgt == LANE_TGT);
  end

  assign sel_ready = (cur_tgt == TGT_VOL) ? vm_req_ready : pm_req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      cur_tgt    <= TGT_NONE;
      cur_write  <= 1'b0;
      cur_offs   <= '0;
      cur_wdata  <= '0;
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            cur_tgt    <= map_tgt;
            cur_write  <= req_write;
            cur_offs   <= map_offs;
            cur_wdata  <= req_wdata;
            rsp_data_q <= '0;
            rsp_err_q  <= (map_tgt == TGT_NONE);
            st         <= (map_tgt == TGT_NONE) ? ST_RESP : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (sel_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (sel_hit) begin
            rsp_data_q <= sel_data;
            st         <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_rdata = rsp_data_q;
  assign rsp_err   = rsp_err_q;

  assign vm_req_valid = be_valid[0];
  assign vm_req_write = cur_write;
  assign vm_req_offs  = cur_offs;
  assign vm_req_wdata = cur_wdata;

  assign pm_req_valid = be_valid[1];
  assign pm_req_write = cur_write;
  assign pm_req_offs  = cur_offs;
  assign pm_req_wdata = cur_wdata;

endmodule

// File: rtl/dpa_router_chk.sv
module dpa_router_chk #(
  parameter int ADDR_W     = 36,
  parameter int DATA_W     = 64,
  parameter int UNIT_SHIFT = 28
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [ADDR_W-1:0]          cfg_vol_bytes,
  input logic [ADDR_W-1:0]          cfg_pers_bytes,
  input logic                       req_valid,
  input logic                       req_ready,
  input logic                       rsp_valid,
  input logic                       rsp_ready,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic                       rsp_err,
  input logic                       vm_req_valid,
  input logic                       vm_req_ready,
  input logic                       vm_req_write,
  input logic [ADDR_W-1:0]          vm_req_offs,
  input logic                       pm_req_valid,
  input logic                       pm_req_ready,
  input logic                       pm_req_write,
  input logic [ADDR_W-1:0]          pm_req_offs,
  input logic [ADDR_W-UNIT_SHIFT:0] id_total_units,
  input logic [ADDR_W-UNIT_SHIFT:0] id_vol_units,
  input logic [ADDR_W-UNIT_SHIFT:0] id_pers_units,
  input logic                       id_align_err
);

  assert_vol_offs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vm_req_valid |-> (vm_req_offs < cfg_vol_bytes));

  assert_pers_offs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req_valid |-> (pm_req_offs < cfg_pers_bytes));

  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vm_req_valid, pm_req_valid}));

  assert_align_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_align_err |-> (id_total_units == '0 && id_vol_units == '0 && id_pers_units == '0));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_vol_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_req_valid && !vm_req_ready) |=>
      (vm_req_valid && $stable(vm_req_offs) && $stable(vm_req_write)));

  assert_pers_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_req_valid && !pm_req_ready) |=>
      (pm_req_valid && $stable(pm_req_offs) && $stable(pm_req_write)));

endmodule

bind dpa_router dpa_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNIT_SHIFT(UNIT_SHIFT)
) u_chk (.*);

// File: tb/dpa_router_test.sv
module dpa_router_test;
  localparam int AW = 36;
  localparam int DW = 64;
  localparam int US = 28;
  localparam int UW = AW - US + 1;
  localparam longint U = 64'd1 << US;
  localparam logic [63:0] VOL_PAT  = 64'h1111_0000_0000_0000;
  localparam logic [63:0] PERS_PAT = 64'h2222_0000_0000_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] cfg_vol_bytes, cfg_pers_bytes;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_valid, rsp_ready, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic          vm_req_valid, vm_req_ready, vm_req_write, vm_rsp_valid;
  logic [AW-1:0] vm_req_offs;
  logic [DW-1:0] vm_req_wdata, vm_rsp_rdata;
  logic          pm_req_valid, pm_req_ready, pm_req_write, pm_rsp_valid;
  logic [AW-1:0] pm_req_offs;
  logic [DW-1:0] pm_req_wdata, pm_rsp_rdata;
  logic [UW-1:0] id_total_units, id_vol_units, id_pers_units;
  logic          id_align_err;

  dpa_router #(.ADDR_W(AW), .DATA_W(DW), .UNIT_SHIFT(US)) uut (.*);

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // Reference state: the expected target of the request in flight
  // (0 volatile, 1 persistent, 2 rejected, 3 none) and its offset.
  int     exp_tgt = 3;
  longint exp_offs = 0;
  longint m_vol = 0, m_pers = 0;
  logic [63:0] shadow [longint];
  logic [63:0] vmem [longint];
  logic [63:0] pmem [longint];
  int vm_cnt = 0, pm_cnt = 0, vm_wait = 0, pm_wait = 0;
  bit vm_stall = 0, pm_stall = 0;
  logic [AW-1:0] vm_stall_offs, pm_stall_offs;

  task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Volatile store model
  always @(negedge clk) begin
    if (!rst_n) begin
      vm_req_ready = 0; vm_rsp_valid = 0; vm_rsp_rdata = '0; vm_wait = 0; vm_stall = 0;
    end else begin
      vm_rsp_valid = 0;
      if (vm_wait > 0) begin vm_wait--; if (vm_wait == 0) vm_rsp_valid = 1; end
      if (vm_stall)
        chk(vm_req_valid && vm_req_offs == vm_stall_offs, "R10", "volatile request held",
            vm_req_offs, vm_stall_offs);
      vm_req_ready = (cyc % 3) != 1;
      vm_stall = vm_req_valid && !vm_req_ready;
      vm_stall_offs = vm_req_offs;
      if (vm_req_valid && vm_req_ready) begin
        vm_cnt++;
        chk(exp_tgt == 0, "R1", "volatile store selected", 64'(exp_tgt), 0);
        chk(longint'(vm_req_offs) == exp_offs, "R1", "volatile offset", vm_req_offs, exp_offs);
        if (vm_req_write) begin vmem[vm_req_offs] = vm_req_wdata; vm_rsp_rdata = '0; end
        else vm_rsp_rdata = vmem.exists(vm_req_offs) ? vmem[vm_req_offs] : (VOL_PAT ^ 64'(vm_req_offs));
        vm_wait = 2;
      end
    end
  end

  // Persistent store model
  always @(negedge clk) begin
    if (!rst_n) begin
      pm_req_ready = 0; pm_rsp_valid = 0; pm_rsp_rdata = '0; pm_wait = 0; pm_stall = 0;
    end else begin
      pm_rsp_valid = 0;
      if (pm_wait > 0) begin pm_wait--; if (pm_wait == 0) pm_rsp_valid = 1; end
      if (pm_stall)
        chk(pm_req_valid && pm_req_offs == pm_stall_offs, "R10", "persistent request held",
            pm_req_offs, pm_stall_offs);
      pm_req_ready = (cyc % 4) != 2;
      pm_stall = pm_req_valid && !pm_req_ready;
      pm_stall_offs = pm_req_offs;
      if (pm_req_valid && pm_req_ready) begin
        pm_cnt++;
        chk(exp_tgt == 1, (m_vol == 0) ? "R3" : "R2", "persistent store selected", 64'(exp_tgt), 1);
        chk(longint'(pm_req_offs) == exp_offs, (m_vol == 0) ? "R3" : "R2", "persistent offset",
            pm_req_offs, exp_offs);
        if (pm_req_write) begin pmem[pm_req_offs] = pm_req_wdata; pm_rsp_rdata = '0; end
        else pm_rsp_rdata = pmem.exists(pm_req_offs) ? pmem[pm_req_offs] : (PERS_PAT ^ 64'(pm_req_offs));
        pm_wait = 2;
      end
    end
  end

  // Per-cycle comparison of capacity fields and of the rejected-request path
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      longint t, ev, ep;
      bit e;
      t = longint'(cfg_vol_bytes) + longint'(cfg_pers_bytes);
      e = (t % U) != 0;
      ev = e ? 0 : longint'(cfg_vol_bytes) / U;
      ep = e ? 0 : longint'(cfg_pers_bytes) / U;
      chk(id_align_err == e, "R7", "alignment error", id_align_err, 64'(e));
      chk(longint'(id_total_units) == (e ? 0 : t / U), e ? "R7" : "R5", "total units",
          id_total_units, e ? 0 : t / U);
      chk(longint'(id_vol_units) == ev, e ? "R7" : "R6", "volatile units", id_vol_units, ev);
      chk(longint'(id_pers_units) == ep, e ? "R7" : "R6", "persistent units", id_pers_units, ep);
      if (exp_tgt == 2)
        chk(!vm_req_valid && !pm_req_valid, "R4", "no store request on reject",
            {vm_req_valid, pm_req_valid}, 0);
    end
  end

  task automatic set_cfg(longint v, longint p);
    @(negedge clk);
    cfg_vol_bytes = AW'(v); cfg_pers_bytes = AW'(p);
    m_vol = v; m_pers = p;
    shadow.delete(); vmem.delete(); pmem.delete();
  endtask

  task automatic access(bit wr, longint a, logic [63:0] d, int hold);
    int et, v0, p0;
    longint eo;
    logic [63:0] er, snap_d;
    bit ee, snap_e;
    string rq;
    if (a < m_vol) begin et = 0; eo = a; rq = "R1"; end
    else if (a < m_vol + m_pers) begin et = 1; eo = a - m_vol; rq = (m_vol == 0) ? "R3" : "R2"; end
    else begin et = 2; eo = 0; rq = "R4"; end
    ee = (et == 2);
    if (wr || ee) er = '0;
    else if (shadow.exists(a)) er = shadow[a];
    else er = ((et == 0) ? VOL_PAT : PERS_PAT) ^ 64'(eo);
    if (wr && !ee) shadow[a] = d;
    v0 = vm_cnt; p0 = pm_cnt;
    @(negedge clk);
    exp_tgt = et; exp_offs = eo;
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R8", "ready low after accept", req_ready, 0);
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      snap_d = rsp_rdata; snap_e = rsp_err;
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == snap_d && rsp_err == snap_e, "R9", "response held",
          rsp_rdata, snap_d);
    end
    chk(rsp_err == ee, rq, "error flag", rsp_err, 64'(ee));
    chk(rsp_rdata == er, (wr || ee) ? rq : "R11", "response data", rsp_rdata, er);
    chk((vm_cnt - v0) == ((et == 0) ? 1 : 0), rq, "volatile request count", vm_cnt - v0, (et == 0) ? 1 : 0);
    chk((pm_cnt - p0) == ((et == 1) ? 1 : 0), rq, "persistent request count", pm_cnt - p0, (et == 1) ? 1 : 0);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    exp_tgt = 3;
    chk(!rsp_valid && req_ready, "R8", "idle after response", {rsp_valid, req_ready}, 64'b01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; rsp_ready = 0;
    cfg_vol_bytes = '0; cfg_pers_bytes = '0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !vm_req_valid && !pm_req_valid, "R8", "reset outputs idle",
        {rsp_valid, vm_req_valid, pm_req_valid}, 0);
    chk(req_ready, "R8", "ready in reset idle", req_ready, 1);
    rst_n = 1;

    // Both partitions present, aligned: R1 R2 R5 R6 R11
    set_cfg(2 * U, 4 * U);
    access(0, 0, '0, 0);
    access(0, 2 * U - 8, '0, 2);
    access(0, 2 * U, '0, 0);
    access(1, 3 * U + 64, 64'hDEAD_BEEF_0123_4567, 1);
    access(0, 3 * U + 64, '0, 3);
    access(1, 5, 64'hCAFE_0000_0000_0005, 0);
    access(0, 5, '0, 0);
    access(0, 6 * U - 1, '0, 0);
    access(0, 6 * U, '0, 2);                            // R4 first address past end
    access(1, 6 * U + 8, 64'h5555_5555_5555_5555, 0);   // R4 rejected write
    // No volatile capacity: R3
    set_cfg(0, U);
    access(0, 0, '0, 0);
    access(0, U - 1, '0, 1);
    access(0, U, '0, 0);
    // No persistent capacity: R1 edge, R4
    set_cfg(U, 0);
    access(0, U - 1, '0, 0);
    access(0, U, '0, 0);
    // Halves of a unit: total aligned, separate fields floor to 0 (R6)
    set_cfg(U / 2, U / 2);
    access(0, U / 2, '0, 0);
    access(0, U / 2 - 1, '0, 0);
    // Misaligned total (R7), routing still active
    set_cfg(U, U + 4096);
    access(0, 2 * U, '0, 0);
    access(0, 2 * U + 4096, '0, 0);
    // Empty device: every address rejected (R4)
    set_cfg(0, 0);
    access(0, 0, '0, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule